// File: doc/BRIEF.md
# Sixteen-bit opcode-mapped ALU

This block is a purely combinational arithmetic and logic unit for a sixteen-bit datapath. Two operands, A and B, enter together with a four-bit operation code. A single sixteen-bit result leaves the block. The operation code selects the function from a fixed map that mixes one-operand operations with two-operand operations. The one-operand set is increment, decrement, inversion and one-place shifts. The two-operand set is addition, subtraction and the three bitwise combinations.

The block holds no state and has no clock. The consumer registers the result in the same cycle in which it applies the operands and the code. All arithmetic wraps modulo 2^16. There are no carry, borrow or overflow outputs. Both shifts move A by exactly one place and fill the vacated bit with zero. Codes that have no function assigned drive a result of zero.

Top module: `opmap_alu`

## Requirements
- R1: Code 4'b0000 gives A + 1 and wraps at the top (0x001F gives 0x0020; 0xFFFF gives 0x0000).
- R2: Code 4'b0001 gives A - 1 and wraps at the bottom (0x1000 gives 0x0FFF; 0x0000 gives 0xFFFF).
- R3: Code 4'b0111 gives A + B modulo 2^16 (0x0111 + 0x0F21 gives 0x1032; 0xFFFF + 0x0002 gives 0x0001).
- R4: Code 4'b1000 gives A - B modulo 2^16 (0x7321 - 0x6421 gives 0x0F00; 0x0000 - 0x0001 gives 0xFFFF).
- R5: Code 4'b1010 gives the bitwise AND of A and B.
- R6: Code 4'b1011 gives the bitwise OR of A and B.
- R7: Code 4'b1100 gives the bitwise XOR of A and B (0x0101 with 0x0011 gives 0x0110).
- R8: Code 4'b1101 gives the bitwise inverse of A (0x0A0C gives 0xF5F3).
- R9: Code 4'b1110 shifts A one place toward the MSB, drops the old MSB and puts zero in bit 0 (0x7310 gives 0xE620).
- R10: Code 4'b1111 shifts A one place toward the LSB, drops the old bit 0 and puts zero in the MSB (0xC426 gives 0x6213).
- R11: The unassigned codes 4'b0010 through 4'b0110 and 4'b1001 give 0x0000 for any operands.
- R12: Under the one-operand codes (4'b0000, 4'b0001, 4'b1101, 4'b1110, 4'b1111), B has no effect on the result.
- R13: The result follows any change of A, B or the code with no clock edge in between. The block adds no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand, and the only operand of the one-operand codes |
| b_i | input | 16 | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 16 | Combinational result |

## Verification
Every result is due in the same cycle as its stimulus. The path has no register, so no clock edge falls between a change of operands or code and the new result. The bench changes the inputs a few nanoseconds after a rising edge and samples the output five nanoseconds later, well before the next edge. Each value it reads therefore comes from the inputs of that cycle alone. For R13 the bench changes the inputs and reads the result again with no clock edge in between. For R12 it holds A and the code fixed, swaps in a very different B, and reads the output again.

// File: rtl/opmap_alu_pkg.sv
package opmap_alu_pkg;

  // Operation codes; the encoding is the external contract of the block.
  typedef enum logic [3:0] {
    OP_INC = 4'b0000,
    OP_DEC = 4'b0001,
    OP_ADD = 4'b0111,
    OP_SUB = 4'b1000,
    OP_AND = 4'b1010,
    OP_OR  = 4'b1011,
    OP_XOR = 4'b1100,
    OP_NOT = 4'b1101,
    OP_SHL = 4'b1110,
    OP_SHR = 4'b1111
  } alu_op_e;

  // Which functional unit produces the result for a code.
  typedef enum logic [1:0] {
    UNIT_NONE  = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_LOGIC = 2'd2,
    UNIT_SHIFT = 2'd3
  } alu_unit_e;

  function automatic alu_unit_e unit_of(input logic [3:0] op);
    alu_unit_e u;
    case (op)
      OP_INC, OP_DEC, OP_ADD, OP_SUB: u = UNIT_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NOT:  u = UNIT_LOGIC;
      OP_SHL, OP_SHR:                 u = UNIT_SHIFT;
      default:                        u = UNIT_NONE;
    endcase
    return u;
  endfunction

  // Codes whose result depends on A only.
  function automatic logic is_unary(input logic [3:0] op);
    logic r;
    case (op)
      OP_INC, OP_DEC, OP_NOT, OP_SHL, OP_SHR: r = 1'b1;
      default:                                r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/opmap_alu_addsub.sv
module opmap_alu_addsub
  import opmap_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] sum_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  // Bit-serial carry chain; the carry out of the top bit is discarded,
  // which makes every operation wrap modulo 2^WIDTH.
  function automatic logic [WIDTH-1:0] ripple_add(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             cin
  );
    logic [WIDTH-1:0] s;
    logic             c;
    c = cin;
    for (int i = 0; i < WIDTH; i++) begin
      s[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    return s;
  endfunction

  // Second adder input and carry-in chosen per code, so that one adder
  // serves increment, decrement, addition and subtraction.
  logic [WIDTH-1:0] addend;
  logic             carry_in;

  always_comb begin
    case (op_i)
      OP_INC: begin addend = ALL_ZERO; carry_in = 1'b1; end
      OP_DEC: begin addend = ALL_ONES; carry_in = 1'b0; end
      OP_ADD: begin addend = b_i;      carry_in = 1'b0; end
      OP_SUB: begin addend = ~b_i;     carry_in = 1'b1; end
      default: begin addend = ALL_ZERO; carry_in = 1'b0; end
    endcase
  end

  assign sum_o = ripple_add(a_i, addend, carry_in);

  // Subtraction checked through its inverse: difference plus B restores A.
  always_comb begin
    if (op_i == OP_SUB) begin
      p_sub_inverse_r4: assert (sum_o + b_i == a_i);
    end
  end

endmodule

// File: rtl/opmap_alu_bitwise.sv
module opmap_alu_bitwise
  import opmap_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  // Single-bit function of the logic codes; other codes give zero.
  function automatic logic bit_func(
    input logic [3:0] op,
    input logic       x,
    input logic       y
  );
    logic r;
    case (op)
      OP_AND:  r = x & y;
      OP_OR:   r = x | y;
      OP_XOR:  r = x ^ y;
      OP_NOT:  r = ~x;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // One slice per bit position.
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign res_o[i] = bit_func(op_i, a_i[i], b_i[i]);
  end

  // Each check states a property of the function, not its formula.
  always_comb begin
    if (op_i == OP_AND) begin
      p_and_within_a_r5: assert ((res_o & ~a_i) == ALL_ZERO);
      p_and_within_b_r5: assert ((res_o & ~b_i) == ALL_ZERO);
    end
    if (op_i == OP_OR) begin
      p_or_covers_r6: assert ((res_o & a_i) == a_i && (res_o & b_i) == b_i);
    end
    if (op_i == OP_XOR) begin
      p_xor_undo_r7: assert ((res_o ^ b_i) == a_i);
    end
    if (op_i == OP_NOT) begin
      p_not_disjoint_r8: assert ((res_o & a_i) == ALL_ZERO);
      p_not_cover_r8:    assert ((res_o | a_i) == ALL_ONES);
    end
  end

endmodule

// File: rtl/opmap_alu_shifter.sv
module opmap_alu_shifter
  import opmap_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o
);

  localparam int MSB = WIDTH - 1;

  logic to_msb;
  logic to_lsb;

  assign to_msb = (op_i == OP_SHL);
  assign to_lsb = (op_i == OP_SHR);

  // Each output bit takes its lower or upper neighbour; the end bits
  // have only one neighbour, so the vacated position receives zero.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_low_end
      assign res_o[i] = to_lsb & a_i[i+1];
    end else if (i == MSB) begin : g_high_end
      assign res_o[i] = to_msb & a_i[i-1];
    end else begin : g_mid
      assign res_o[i] = (to_msb & a_i[i-1]) | (to_lsb & a_i[i+1]);
    end
  end

  always_comb begin
    if (to_msb) begin
      p_shl_fill_r9: assert (res_o[0] == 1'b0);
    end
    if (to_lsb) begin
      p_shr_fill_r10: assert (res_o[MSB] == 1'b0);
    end
  end

endmodule

// File: rtl/opmap_alu.sv
module opmap_alu
  import opmap_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o
);

  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  // Unit results and selects, named so the checks below can see them.
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] shift_res;
  alu_unit_e        unit_sel;
  logic             sel_arith;
  logic             sel_logic;
  logic             sel_shift;

  opmap_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .sum_o (arith_res)
  );

  opmap_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .res_o (logic_res)
  );

  opmap_alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .a_i   (a_i),
    .op_i  (op_i),
    .res_o (shift_res)
  );

  assign unit_sel  = unit_of(op_i);
  assign sel_arith = (unit_sel == UNIT_ARITH);
  assign sel_logic = (unit_sel == UNIT_LOGIC);
  assign sel_shift = (unit_sel == UNIT_SHIFT);

  // AND-OR result mux: an unassigned code enables no unit and yields zero.
  assign result_o = ({WIDTH{sel_arith}} & arith_res)
                  | ({WIDTH{sel_logic}} & logic_res)
                  | ({WIDTH{sel_shift}} & shift_res);

  // Port-level checks, each phrased as an inverse or a neighbour relation.
  always_comb begin
    p_one_unit_r11: assert ($onehot0({sel_arith, sel_logic, sel_shift}));
    if (op_i == OP_INC) begin
      p_inc_inverse_r1: assert (result_o - ONE == a_i);
    end
    if (op_i == OP_DEC) begin
      p_dec_inverse_r2: assert (result_o + ONE == a_i);
    end
    if (op_i == OP_ADD) begin
      p_add_inverse_r3: assert (result_o - b_i == a_i);
    end
    if (op_i == OP_SHL) begin
      p_shl_move_r9: assert (result_o[WIDTH-1:1] == a_i[WIDTH-2:0]);
    end
    if (op_i == OP_SHR) begin
      p_shr_move_r10: assert (result_o[WIDTH-2:0] == a_i[WIDTH-1:1]);
    end
    if (unit_sel == UNIT_NONE) begin
      p_unassigned_zero_r11: assert (result_o == ALL_ZERO);
    end
    if (is_unary(op_i)) begin
      p_unary_no_logic_b_r12: assert (!(sel_logic && op_i != OP_NOT));
    end
  end

endmodule

// File: tb/opmap_alu_tb.sv
module opmap_alu_tb_top;

  logic        clk;
  logic [15:0] a;
  logic [15:0] b;
  logic [3:0]  op;
  logic [15:0] res;
  int          n_checks;
  int          n_fails;
  bit          finished;

  opmap_alu #(.WIDTH(16)) dut_i (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (res)
  );

  // 50 MHz clock
  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] exp);
    n_checks++;
    if (res !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, res, exp);
    end
  endtask

  // Drive a few ns after the edge, sample mid-cycle.
  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y);
    @(posedge clk);
    #3;
    op = o;
    a  = x;
    b  = y;
    #5;
  endtask

  // Independent models: shifts through multiply/divide, arithmetic in 17 bits.
  function automatic logic [15:0] m_add(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] w;
    w = {1'b0, x} + {1'b0, y};
    return w[15:0];
  endfunction

  function automatic logic [15:0] m_sub(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] w;
    w = {1'b1, x} - {1'b0, y};
    return w[15:0];
  endfunction

  task automatic t_initial;
    #5;
    check("R1 initial inputs zero, increment gives 0001", 16'h0001);
  endtask

  task automatic t_inc;
    apply(4'b0000, 16'h001F, 16'h0000); check("R1 inc 001F", 16'h0020);
    apply(4'b0000, 16'hFFFF, 16'h0000); check("R1 inc wrap FFFF", 16'h0000);
    apply(4'b0000, 16'h7FFF, 16'h0000); check("R1 inc 7FFF", 16'h8000);
  endtask

  task automatic t_dec;
    apply(4'b0001, 16'h1000, 16'h0000); check("R2 dec 1000", 16'h0FFF);
    apply(4'b0001, 16'h0000, 16'h0000); check("R2 dec wrap 0000", 16'hFFFF);
  endtask

  task automatic t_add;
    apply(4'b0111, 16'h0111, 16'h0F21); check("R3 add stated", 16'h1032);
    apply(4'b0111, 16'hFFFF, 16'h0002); check("R3 add wrap", 16'h0001);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] x;
      logic [15:0] y;
      x = 16'(k * 16'h2D3B + 16'h1111);
      y = 16'(k * 16'h9E05 + 16'h0F0F);
      apply(4'b0111, x, y); check("R3 add sweep", m_add(x, y));
    end
  endtask

  task automatic t_sub;
    apply(4'b1000, 16'h7321, 16'h6421); check("R4 sub stated", 16'h0F00);
    apply(4'b1000, 16'h0000, 16'h0001); check("R4 sub borrow wrap", 16'hFFFF);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] x;
      logic [15:0] y;
      x = 16'(k * 16'h3141 + 16'h0203);
      y = 16'(k * 16'h5927 + 16'h1000);
      apply(4'b1000, x, y); check("R4 sub sweep", m_sub(x, y));
    end
  endtask

  task automatic t_logic;
    apply(4'b1010, 16'h0FA6, 16'hFA84); check("R5 and", 16'h0A84);
    apply(4'b1010, 16'hFFFF, 16'h0000); check("R5 and zero", 16'h0000);
    apply(4'b1011, 16'h0101, 16'h0011); check("R6 or", 16'h0111);
    apply(4'b1011, 16'hF000, 16'h000F); check("R6 or disjoint", 16'hF00F);
    apply(4'b1100, 16'h0101, 16'h0011); check("R7 xor stated", 16'h0110);
    apply(4'b1100, 16'hAAAA, 16'hFFFF); check("R7 xor invert", 16'h5555);
    apply(4'b1101, 16'h0A0C, 16'h0000); check("R8 not stated", 16'hF5F3);
    apply(4'b1101, 16'h0000, 16'h1234); check("R8 not zero", 16'hFFFF);
  endtask

  task automatic t_shift;
    apply(4'b1110, 16'h7310, 16'h0000); check("R9 shl stated", 16'hE620);
    apply(4'b1110, 16'h8001, 16'h0000); check("R9 shl drops msb", 16'h0002);
    apply(4'b1111, 16'hC426, 16'h0000); check("R10 shr stated", 16'h6213);
    apply(4'b1111, 16'h8001, 16'h0000); check("R10 shr drops lsb", 16'h4000);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] x;
      x = 16'(k * 16'h6B4D + 16'h8421);
      apply(4'b1110, x, 16'hFFFF); check("R9 shl sweep", 16'(x * 2));
      apply(4'b1111, x, 16'hFFFF); check("R10 shr sweep", x / 16'd2);
    end
  endtask

  task automatic t_unassigned;
    logic [3:0] codes [6];
    codes = '{4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b1001};
    foreach (codes[k]) begin
      apply(codes[k], 16'hFFFF, 16'hFFFF); check("R11 unassigned code gives zero", 16'h0000);
      apply(codes[k], 16'h1234, 16'h8765); check("R11 unassigned code gives zero", 16'h0000);
    end
  endtask

  task automatic t_unary_ignores_b;
    logic [3:0] codes [5];
    logic [15:0] first;
    codes = '{4'b0000, 4'b0001, 4'b1101, 4'b1110, 4'b1111};
    foreach (codes[k]) begin
      apply(codes[k], 16'h5A3C, 16'h0000);
      first = res;
      #1 b = 16'hFFFF;
      #2 check("R12 unary code unaffected by B", first);
    end
  endtask

  task automatic t_no_latency;
    apply(4'b0111, 16'h0001, 16'h0001);
    check("R13 first value", 16'h0002);
    #1 a = 16'h0100;
    #1 check("R13 follows A without an edge", 16'h0101);
    #1 op = 4'b1100;
    #1 check("R13 follows code without an edge", 16'h0101);
    #1 b = 16'h0100;
    #1 check("R13 follows B without an edge", 16'h0000);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    a  = 16'h0000;
    b  = 16'h0000;
    op = 4'b0000;
    t_initial();
    t_inc();
    t_dec();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_unassigned();
    t_unary_ignores_b();
    t_no_latency();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule